// File: doc/BRIEF.md
# Fast Ethernet Receive Symbol Decoder

This block turns a stream of three-level line symbols, one per cycle of a recovered 125 MHz symbol clock, into a receive nibble interface for a MAC. Each symbol arrives already sliced to a 2-bit level code. Two transition-detecting stages turn the levels into plain serial bits. A self-synchronising descrambler then strips the 11-bit key stream. An aligner finds the start-of-stream code-group pair, splits the bit stream into 5-bit groups and maps each group back to a nibble.

The descrambler has no seed of its own. While the line carries idle, which is all ones before scrambling, it fills its key register from the inverted received bits. It declares lock once enough consecutive bits agree with its own prediction. If no run of idle ones is seen for a long stretch, it drops lock and hunts again.

The nibble outputs run at one fifth of the symbol rate. They change only on the cycle that carries a one-cycle strobe and hold their values until the next strobe.

Top module: `fe_rx_decoder`

## Requirements
- R1: The level code on `rx_sym` reads 2'b01 as positive, 2'b11 as negative, and both 2'b00 and 2'b10 as the zero level.
- R2: A received bit is 1 when the line level differs from the previous symbol's level. A descrambler input bit is 1 when that received bit differs from the one before it.
- R3: The descrambler key follows k[n] = k[n-11] xor k[n-9]. While hunting, the key register loads the inverted input bits. `rx_locked` rises after LOCK_RUN consecutive input bits agree with the predicted key, and bits are descrambled from then on.
- R4: A scrambled stream whose plain content is not idle (for example all zeros) never brings the descrambler into lock.
- R5: While locked, if LOCK_TMO bits pass without a run of IDLE_RUN plain ones, `rx_locked` falls. It stays up while such runs keep recurring.
- R6: Group alignment starts at the 10-bit pattern 1100010001 (first bit received at the left). The first group after that pattern is the first nibble delivered with `rx_dv` high, at any bit offset of the pattern.
- R7: Each group in a frame produces one `rx_nib_stb` pulse. Outputs change only on a strobe cycle. Data groups map 11110→0, 01001→1, 10100→2, 10101→3, 01010→4, 01011→5, 01110→6, 01111→7, 10010→8, 10011→9, 10110→A, 10111→B, 11010→C, 11011→D, 11100→E, 11101→F, with the first bit received as the leftmost bit.
- R8: The group 01101 ends a frame with a strobe that carries `rx_dv` low. The group that follows it and the idle after it start no new frame.
- R9: Any other group inside a frame is delivered with `rx_dv` and `rx_er` both high, and the frame continues. `rx_er` is never high without `rx_dv`.
- R10: An idle group 11111 inside a frame ends the frame with `rx_dv` low and `rx_er` low.
- R11: After reset `rxd`, `rx_dv`, `rx_er`, `rx_nib_stb` and `rx_locked` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered 125 MHz symbol clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_sym | input | 2 | Sliced line level of the current symbol |
| rxd | output | 4 | Received nibble |
| rx_dv | output | 1 | Frame data valid |
| rx_er | output | 1 | Bad code group in the frame |
| rx_nib_stb | output | 1 | One-cycle pulse when the nibble outputs update |
| rx_locked | output | 1 | Descrambler locked |

## Verification
The bench puts start-of-stream patterns at different bit offsets. A design that aligns to a fixed phase would deliver shifted, wrong nibbles. It feeds a long stretch of scrambled zeros to check both sides of the lock timeout: a counter that is too short drops lock early, and a missing timeout never drops it. Further zeros must not relock a design whose hunt ignores the idle content. Frames carry an invalid group and an idle cut-off, and they use the alternate zero-level code. These catch a decoder that ends the frame on an error, flags the idle cut-off as an error, or misreads the alternate code as a level change.

// File: rtl/fe_rx_pkg.sv
package fe_rx_pkg;

  localparam logic [9:0] CG_SSD  = 10'b1100010001;
  localparam logic [4:0] CG_END  = 5'b01101;
  localparam logic [4:0] CG_IDLE = 5'b11111;

  typedef struct packed {
    logic       ok;
    logic [3:0] nib;
  } grp_dec_t;

  // fold the alternate zero code onto the plain zero level
  function automatic logic [1:0] lvl_norm(input logic [1:0] s);
    return (s == 2'b10) ? 2'b00 : s;
  endfunction

  // next key bit from the 11-bit history, newest bit in [0]
  function automatic logic scr_key(input logic [10:0] st);
    return st[10] ^ st[8];
  endfunction

  function automatic grp_dec_t dec_4b5b(input logic [4:0] g);
    grp_dec_t r;
    r.ok = 1'b1;
    case (g)
      5'b11110: r.nib = 4'h0;
      5'b01001: r.nib = 4'h1;
      5'b10100: r.nib = 4'h2;
      5'b10101: r.nib = 4'h3;
      5'b01010: r.nib = 4'h4;
      5'b01011: r.nib = 4'h5;
      5'b01110: r.nib = 4'h6;
      5'b01111: r.nib = 4'h7;
      5'b10010: r.nib = 4'h8;
      5'b10011: r.nib = 4'h9;
      5'b10110: r.nib = 4'hA;
      5'b10111: r.nib = 4'hB;
      5'b11010: r.nib = 4'hC;
      5'b11011: r.nib = 4'hD;
      5'b11100: r.nib = 4'hE;
      5'b11101: r.nib = 4'hF;
      default: begin
        r.ok  = 1'b0;
        r.nib = 4'h0;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fe_rx_line.sv
module fe_rx_line
  import fe_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sym_i,
  output logic       nrz_o
);

  logic [1:0] lvl_prev;
  logic       nrzi_q;
  logic       nrzi_d;
  logic [1:0] lvl_now;

  assign lvl_now = lvl_norm(sym_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_prev <= 2'b00;
      nrzi_q   <= 1'b0;
      nrzi_d   <= 1'b0;
      nrz_o    <= 1'b0;
    end else begin
      lvl_prev <= lvl_now;
      nrzi_q   <= (lvl_now != lvl_prev);
      nrzi_d   <= nrzi_q;
      nrz_o    <= nrzi_q ^ nrzi_d;
    end
  end

endmodule

// File: rtl/fe_rx_descr.sv
module fe_rx_descr
  import fe_rx_pkg::*;
#(
  parameter int LOCK_RUN = 30,
  parameter int IDLE_RUN = 12,
  parameter int LOCK_TMO = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_i,
  output logic plain_o,
  output logic plain_vld_o,
  output logic locked_o,
  output logic lock_evt_o,
  output logic tmo_evt_o
);

  localparam int RW = $clog2(LOCK_RUN + 1);
  localparam int OW = $clog2(IDLE_RUN + 1);
  localparam int TW = $clog2(LOCK_TMO + 1);

  logic [10:0]   lfsr;
  logic [RW-1:0] run_cnt;
  logic [OW-1:0] ones_cnt;
  logic [TW-1:0] tmo_cnt;
  logic          key;
  logic          hunt_match;
  logic          plain;
  logic          idle_seen;

  assign key        = scr_key(lfsr);
  assign hunt_match = (~bit_i) == key;
  assign plain      = bit_i ^ key;
  assign idle_seen  = plain && (ones_cnt == OW'(IDLE_RUN - 1));
  assign lock_evt_o = !locked_o && hunt_match && (run_cnt == RW'(LOCK_RUN - 1));
  assign tmo_evt_o  = locked_o && !idle_seen && (tmo_cnt == TW'(LOCK_TMO - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr        <= '0;
      run_cnt     <= '0;
      ones_cnt    <= '0;
      tmo_cnt     <= '0;
      locked_o    <= 1'b0;
      plain_o     <= 1'b0;
      plain_vld_o <= 1'b0;
    end else begin
      plain_o     <= plain;
      plain_vld_o <= locked_o;
      if (!locked_o) begin
        lfsr     <= {lfsr[9:0], ~bit_i};
        ones_cnt <= '0;
        tmo_cnt  <= '0;
        if (lock_evt_o) begin
          locked_o <= 1'b1;
          run_cnt  <= '0;
        end else if (hunt_match) begin
          run_cnt <= run_cnt + 1'b1;
        end else begin
          run_cnt <= '0;
        end
      end else begin
        lfsr <= {lfsr[9:0], key};
        if (!plain) ones_cnt <= '0;
        else if (!idle_seen) ones_cnt <= ones_cnt + 1'b1;
        if (tmo_evt_o) begin
          locked_o <= 1'b0;
          tmo_cnt  <= '0;
        end else if (idle_seen) begin
          tmo_cnt <= '0;
        end else begin
          tmo_cnt <= tmo_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fe_rx_align.sv
module fe_rx_align
  import fe_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_i,
  input  logic       vld_i,
  output logic [3:0] rxd_o,
  output logic       dv_o,
  output logic       er_o,
  output logic       stb_o,
  output logic       jk_hit_o
);

  logic [9:0] sr;
  logic [9:0] sr_n;
  logic [4:0] grp;
  logic [4:0] grp_n;
  logic [2:0] cnt;
  logic       in_frame;
  logic       grp_end;
  grp_dec_t   dec;

  assign sr_n     = {sr[8:0], bit_i};
  assign grp_n    = {grp[3:0], bit_i};
  assign dec      = dec_4b5b(grp_n);
  assign grp_end  = (grp_n == CG_END) || (grp_n == CG_IDLE);
  assign jk_hit_o = vld_i && !in_frame && (sr_n == CG_SSD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr       <= '1;
      grp      <= '0;
      cnt      <= '0;
      in_frame <= 1'b0;
      rxd_o    <= '0;
      dv_o     <= 1'b0;
      er_o     <= 1'b0;
      stb_o    <= 1'b0;
    end else begin
      stb_o <= 1'b0;
      if (!vld_i) begin
        sr  <= '1;
        cnt <= '0;
        if (in_frame) begin
          in_frame <= 1'b0;
          stb_o    <= 1'b1;
          dv_o     <= 1'b0;
          er_o     <= 1'b0;
          rxd_o    <= '0;
        end
      end else if (!in_frame) begin
        sr <= sr_n;
        if (jk_hit_o) begin
          in_frame <= 1'b1;
          cnt      <= '0;
        end
      end else begin
        grp <= grp_n;
        if (cnt == 3'd4) begin
          cnt   <= '0;
          stb_o <= 1'b1;
          if (grp_end) begin
            in_frame <= 1'b0;
            sr       <= '1;
            dv_o     <= 1'b0;
            er_o     <= 1'b0;
            rxd_o    <= '0;
          end else begin
            dv_o  <= 1'b1;
            er_o  <= !dec.ok;
            rxd_o <= dec.nib;
          end
        end else begin
          cnt <= cnt + 3'd1;
        end
      end
    end
  end

endmodule

// File: rtl/fe_rx_decoder.sv
module fe_rx_decoder #(
  parameter int LOCK_RUN = 30,
  parameter int IDLE_RUN = 12,
  parameter int LOCK_TMO = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rx_sym,
  output logic [3:0] rxd,
  output logic       rx_dv,
  output logic       rx_er,
  output logic       rx_nib_stb,
  output logic       rx_locked
);

  logic nrz_bit;
  logic plain_bit;
  logic plain_vld;
  logic lock_evt;
  logic tmo_evt;
  logic jk_hit;

  fe_rx_line u_line (
    .clk   (clk),
    .rst_n (rst_n),
    .sym_i (rx_sym),
    .nrz_o (nrz_bit)
  );

  fe_rx_descr #(
    .LOCK_RUN (LOCK_RUN),
    .IDLE_RUN (IDLE_RUN),
    .LOCK_TMO (LOCK_TMO)
  ) u_descr (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_i       (nrz_bit),
    .plain_o     (plain_bit),
    .plain_vld_o (plain_vld),
    .locked_o    (rx_locked),
    .lock_evt_o  (lock_evt),
    .tmo_evt_o   (tmo_evt)
  );

  fe_rx_align u_align (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_i    (plain_bit),
    .vld_i    (plain_vld),
    .rxd_o    (rxd),
    .dv_o     (rx_dv),
    .er_o     (rx_er),
    .stb_o    (rx_nib_stb),
    .jk_hit_o (jk_hit)
  );

endmodule

// File: rtl/fe_rx_decoder_chk.sv
module fe_rx_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] rxd,
  input logic       rx_dv,
  input logic       rx_er,
  input logic       rx_nib_stb,
  input logic       rx_locked,
  input logic       lock_evt,
  input logic       tmo_evt,
  input logic       jk_hit
);

  p_er_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_er |-> rx_dv);

  p_hold_between_stb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_nib_stb |-> $stable({rxd, rx_dv, rx_er}));

  p_lock_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_locked) |-> $past(lock_evt));

  p_lock_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_locked) |-> $past(tmo_evt));

  p_ssd_outside_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    jk_hit |-> !rx_dv);

endmodule

bind fe_rx_decoder fe_rx_decoder_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rxd        (rxd),
  .rx_dv      (rx_dv),
  .rx_er      (rx_er),
  .rx_nib_stb (rx_nib_stb),
  .rx_locked  (rx_locked),
  .lock_evt   (lock_evt),
  .tmo_evt    (tmo_evt),
  .jk_hit     (jk_hit)
);

// File: tb/test_fe_rx_decoder.sv
module test_fe_rx_decoder;

  localparam int LOCK_TMO = 2000;

  typedef struct {
    bit       er;
    bit [3:0] nib;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rx_sym = 2'b00;
  logic [3:0] rxd;
  logic       rx_dv;
  logic       rx_er;
  logic       rx_nib_stb;
  logic       rx_locked;

  int   n_checks = 0;
  int   n_fail = 0;
  int   ends_seen = 0;
  int   ends_exp = 0;
  exp_t exp_q[$];

  logic [10:0] tx_key = 11'h5A3;
  logic        tx_nrzi = 1'b0;
  int          tx_lvl = 0;
  bit          alt_zero = 1'b0;

  always #2 clk = ~clk;

  fe_rx_decoder #(.LOCK_RUN(30), .IDLE_RUN(12), .LOCK_TMO(LOCK_TMO)) i_fe_rx_decoder (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_sym     (rx_sym),
    .rxd        (rxd),
    .rx_dv      (rx_dv),
    .rx_er      (rx_er),
    .rx_nib_stb (rx_nib_stb),
    .rx_locked  (rx_locked)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [4:0] enc(input logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                           5'b01010, 5'b01011, 5'b01110, 5'b01111,
                           5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  // scramble, then NRZI, then three-level line coding
  task automatic send_bit(input logic b);
    logic k;
    logic s;
    k = tx_key[10] ^ tx_key[8];
    tx_key = {tx_key[9:0], k};
    s = b ^ k;
    tx_nrzi = tx_nrzi ^ s;
    if (tx_nrzi) tx_lvl = (tx_lvl + 1) % 4;
    case (tx_lvl)
      1: rx_sym = 2'b01;
      3: rx_sym = 2'b11;
      default: rx_sym = alt_zero ? 2'b10 : 2'b00;
    endcase
    @(negedge clk);
  endtask

  task automatic send_bits(input int n, input logic b);
    for (int i = 0; i < n; i++) send_bit(b);
  endtask

  task automatic send_grp(input logic [4:0] g);
    for (int i = 4; i >= 0; i--) send_bit(g[i]);
  endtask

  task automatic send_nib(input logic [3:0] n);
    exp_t e;
    e.er = 1'b0;
    e.nib = n;
    exp_q.push_back(e);
    send_grp(enc(n));
  endtask

  task automatic send_bad(input logic [4:0] g);
    exp_t e;
    e.er = 1'b1;
    e.nib = 4'h0;
    exp_q.push_back(e);
    send_grp(g);
  endtask

  task automatic send_ssd();
    send_grp(5'b11000);
    send_grp(5'b10001);
  endtask

  task automatic send_tail();
    send_grp(5'b01101);
    send_grp(5'b00111);
    ends_exp++;
  endtask

  task automatic frame_done(input string req);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    check(rx_dv == 1'b0, req, rx_dv, 0);
    check(ends_seen == ends_exp, req, ends_seen, ends_exp);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rx_nib_stb) begin
      if (!rx_dv) begin
        ends_seen++;
      end else if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected nibble", rxd, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.er) begin
          check(rx_er == 1'b1, "R9 bad group flag", rx_er, 1);
        end else begin
          check(rx_er == 1'b0, "R7 data group flag", rx_er, 0);
          check(rxd == e.nib, "R7/R2 nibble value", rxd, e.nib);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11 reset state
    check(rxd == 4'h0 && rx_dv == 1'b0 && rx_er == 1'b0, "R11 outputs idle in reset",
          {rxd, rx_dv, rx_er}, 0);
    check(rx_nib_stb == 1'b0 && rx_locked == 1'b0, "R11 no lock in reset",
          {rx_nib_stb, rx_locked}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 lock on idle
    send_bits(200, 1'b1);
    check(rx_locked == 1'b1, "R3 lock after idle", rx_locked, 1);

    // first frame: preamble-like nibbles then every data value (R6, R7, R2, R8)
    send_ssd();
    for (int i = 0; i < 4; i++) send_nib(4'h5);
    send_nib(4'hD);
    for (int i = 0; i < 16; i++) send_nib(4'(i));
    send_tail();
    send_bits(60, 1'b1);
    frame_done("R8 first frame end");

    // R5: scrambled zeros, lock holds until the timeout
    send_bits(LOCK_TMO - 60, 1'b0);
    check(rx_locked == 1'b1, "R5 lock held before timeout", rx_locked, 1);
    send_bits(120, 1'b0);
    check(rx_locked == 1'b0, "R5 lock dropped after timeout", rx_locked, 0);
    // R4: non-idle content does not relock
    send_bits(300, 1'b0);
    check(rx_locked == 1'b0, "R4 no relock on zeros", rx_locked, 0);
    send_bits(200, 1'b1);
    check(rx_locked == 1'b1, "R3 relock after idle", rx_locked, 1);

    // second frame with alternate zero code (R1), new offset and a bad group (R9)
    alt_zero = 1'b1;
    send_bits(37, 1'b1);
    send_ssd();
    send_nib(4'hA);
    send_nib(4'h3);
    send_bad(5'b00000);
    send_nib(4'h7);
    send_bad(5'b11000);
    send_nib(4'hF);
    send_tail();
    send_bits(60, 1'b1);
    frame_done("R9/R1 second frame end");

    // third frame cut off by idle groups (R10)
    send_bits(3, 1'b1);
    send_ssd();
    send_nib(4'h1);
    send_nib(4'hE);
    send_nib(4'h0);
    ends_exp++;
    send_bits(60, 1'b1);
    frame_done("R10 idle cut-off");
    check(rx_er == 1'b0, "R10 no error on cut-off", rx_er, 0);
    check(rx_locked == 1'b1, "R5 lock kept with idle", rx_locked, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule